// File: doc/BRIEF.md
# Dual-Port Expansion I/O Registers

This block gives a host two general-purpose I/O ports of eight pins each, reached over a shared 8-bit register bus. Each port owns an output register, which holds the level it drives, and a direction register, with one bit for each pin. A direction bit of 1 makes its pin an output driven from the output register. A direction bit of 0 leaves the pin at high impedance so that it can be read as an input. Input levels pass through a synchroniser before the host can read them.

The host selects a register with a 3-bit select code whose top bit is 1. A rising edge of the active-low write strobe loads the selected register from the data bus. While the active-low output enable is low, the block drives the selected register's read value onto the bus. The active-low chip enable gates all of these accesses. It does not touch the stored register contents or the pin drive. The host interface is sampled on the block clock, and a write strobe edge is seen as a change of the strobe between two clock samples.

Top module: `exio_regs`

## Requirements
- R1: After reset both output registers hold all ones, both direction registers hold 0x00, no pin is driven (pin_oe all 0), pin_o is all ones and data_oe is 0.
- R2: A write happens on the first clock edge at which we_n is sampled 1 after being sampled 0, provided that at that edge ce_n is 0 and rsel is 100 (port 0 output register), 101 (port 1 output register), 110 (port 0 direction) or 111 (port 1 direction). The register takes data_i as sampled at that edge, and the new value is visible after that edge.
- R3: A write strobe edge while rsel[2] is 0 leaves all four registers, pin_o and pin_oe unchanged.
- R4: While ce_n is 1, a write strobe edge changes no register, data_oe stays 0, and pin_o and pin_oe keep their values.
- R5: data_oe is 1 exactly when ce_n is 0, oe_n is 0 and rsel[2] is 1. The read path has no clock delay.
- R6: Reading rsel 110 or 111 returns the stored direction register of port 0 or port 1.
- R7: pin_oe bit i equals direction bit i, and pin_o carries the output register. Port 0 uses bits 7:0 of the pin vectors and port 1 uses bits 15:8. Each bit is controlled on its own.
- R8: Reading rsel 100 or 101 returns, for each bit, the output register bit when that pin's direction bit is 1 and the synchronised pin_i level when it is 0.
- R9: A change on pin_i reaches the read value after exactly two clock edges. After one edge the old level is still returned.
- R10: Holding we_n low or high for any number of cycles writes nothing. Only the low-to-high transition writes, and it uses the data present at that transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable for register access |
| oe_n | input | 1 | Active-low read enable |
| we_n | input | 1 | Active-low write strobe; its rising edge writes |
| rsel | input | 3 | Register select code |
| data_i | input | DATA_W | Write data from the host |
| data_o | output | DATA_W | Read data to the host |
| data_oe | output | 1 | Drive enable for the host data bus |
| pin_i | input | 2*PORT_W | Sampled levels of the port pins |
| pin_o | output | 2*PORT_W | Output levels of the port pins |
| pin_oe | output | 2*PORT_W | Per-pin drive enable (1 = output) |

## Verification
Both ports are swept over all 256 direction patterns. The output register value and the pin levels are derived arithmetically from the direction pattern, so every pattern mixes outputs and inputs differently, and each read shows which source fed each bit. The all-input and all-output patterns single out the two sources in turn. The alternating and nibble patterns would expose a swapped, shifted or shared direction bit between neighbouring pins or between the ports. Separate sequences hold the strobe low while the data changes, write with chip enable high, write with low select codes and move a pin level one edge at a time. These show write-edge detection apart from level-sensitive writing, and synchroniser depth apart from a direct pin read.

// File: rtl/exio_pkg.sv
package exio_pkg;
   localparam int unsigned SEL_W   = 3;
   localparam int unsigned NUM_REG = 4;

   // low two select bits name the register once the top bit is set
   typedef enum logic [1:0] {
      REG_PORT0 = 2'b00,
      REG_PORT1 = 2'b01,
      REG_DIR0  = 2'b10,
      REG_DIR1  = 2'b11
   } exio_reg_e;

   function automatic exio_reg_e sel_to_reg(input logic [SEL_W-1:0] s);
      return exio_reg_e'(s[1:0]);
   endfunction
endpackage

// File: rtl/exio_sync.sv
module exio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("exio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/exio_decode.sv
module exio_decode
   import exio_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce_n,
   input  logic                 oe_n,
   input  logic                 we_n,
   input  logic [SEL_W-1:0]     rsel,
   output logic [NUM_REG-1:0]   wr_en,
   output logic                 rd_en,
   output exio_reg_e            rd_sel
);
   logic we_q;
   logic we_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   assign we_rise = we_n & ~we_q;
   assign rd_sel  = sel_to_reg(rsel);
   assign rd_en   = ~ce_n & ~oe_n & rsel[SEL_W-1];

   always_comb begin
      wr_en = '0;
      if (we_rise && !ce_n && rsel[SEL_W-1]) wr_en[rd_sel] = 1'b1;
   end
endmodule

// File: rtl/exio_port.sv
module exio_port #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_port,
   input  logic             wr_dir,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] port_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] port_rd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q <= '1;
         dir_q  <= '0;
      end else begin
         if (wr_port) port_q <= wdata;
         if (wr_dir)  dir_q  <= wdata;
      end
   end

   // output pins echo the register, input pins show the synchronised level
   assign port_rd = (port_q & dir_q) | (pin_sync & ~dir_q);
endmodule

// File: rtl/exio_regs.sv
module exio_regs
   import exio_pkg::*;
#(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ce_n,
   input  logic                  oe_n,
   input  logic                  we_n,
   input  logic [2:0]            rsel,
   input  logic [DATA_W-1:0]     data_i,
   output logic [DATA_W-1:0]     data_o,
   output logic                  data_oe,
   input  logic [2*PORT_W-1:0]   pin_i,
   output logic [2*PORT_W-1:0]   pin_o,
   output logic [2*PORT_W-1:0]   pin_oe
);
   localparam int unsigned NUM_PORT = 2;
   localparam int unsigned PAD_W    = DATA_W - PORT_W;

   if (PORT_W < 1 || PORT_W > DATA_W) begin : g_bad_width
      $error("exio_regs: PORT_W must be in 1..DATA_W");
   end

   logic [NUM_REG-1:0] wr_en;
   logic               rd_en;
   exio_reg_e          rd_sel;
   logic [PORT_W-1:0]  port_q  [NUM_PORT];
   logic [PORT_W-1:0]  dir_q   [NUM_PORT];
   logic [PORT_W-1:0]  port_rd [NUM_PORT];
   logic [PORT_W-1:0]  rd_val;

   exio_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .we_n   (we_n),
      .rsel   (rsel),
      .wr_en  (wr_en),
      .rd_en  (rd_en),
      .rd_sel (rd_sel)
   );

   for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
      logic [PORT_W-1:0] pin_s;

      exio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (pin_i[p*PORT_W +: PORT_W]),
         .dout  (pin_s)
      );

      exio_port #(.WIDTH(PORT_W)) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_port  (wr_en[p]),
         .wr_dir   (wr_en[NUM_PORT + p]),
         .wdata    (data_i[PORT_W-1:0]),
         .pin_sync (pin_s),
         .port_q   (port_q[p]),
         .dir_q    (dir_q[p]),
         .port_rd  (port_rd[p])
      );

      assign pin_o [p*PORT_W +: PORT_W] = port_q[p];
      assign pin_oe[p*PORT_W +: PORT_W] = dir_q[p];
   end

   always_comb begin
      unique case (rd_sel)
         REG_PORT0: rd_val = port_rd[0];
         REG_PORT1: rd_val = port_rd[1];
         REG_DIR0:  rd_val = dir_q[0];
         default:   rd_val = dir_q[1];
      endcase
   end

   if (PAD_W == 0) begin : g_no_pad
      assign data_o = rd_val;
      logic unused_hi;
      assign unused_hi = 1'b0;
   end else begin : g_pad
      assign data_o = {{PAD_W{1'b0}}, rd_val};
      logic unused_hi;
      assign unused_hi = ^data_i[DATA_W-1:PORT_W];
   end

   assign data_oe = rd_en;
endmodule

// File: rtl/exio_regs_chk.sv
module exio_regs_chk #(
   parameter int unsigned PORT_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ce_n,
   input logic                oe_n,
   input logic                we_n,
   input logic [2:0]          rsel,
   input logic [DATA_W-1:0]   data_o,
   input logic                data_oe,
   input logic [2*PORT_W-1:0] pin_o,
   input logic [2*PORT_W-1:0] pin_oe
);
   // R1: reset puts every pin in input mode with the output registers all ones
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pin_o == '1));

   // R3: low select codes never alter the port state
   a_r3_low_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !rsel[2] |=> ($stable(pin_o) && $stable(pin_oe)));

   // R4: deselected chip keeps pin state and leaves the bus undriven
   a_r4_ce_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> ($stable(pin_o) && $stable(pin_oe)));

   a_r4_ce_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> !data_oe);

   // R5: bus driven only for an enabled read of an expansion register
   a_r5_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || !rsel[2]) |-> !data_oe);

   // R10: no strobe transition means no register change
   a_r10_level_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we_n == $past(we_n)) |=> ($stable(pin_o) && $stable(pin_oe)));

   // R8: output-mode bits of a port read match the driven pin levels
   a_r8_out_bits_p0: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && rsel == 3'b100) |->
         (((data_o[PORT_W-1:0] ^ pin_o[PORT_W-1:0]) & pin_oe[PORT_W-1:0]) == '0));

   a_r8_out_bits_p1: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && rsel == 3'b101) |->
         (((data_o[PORT_W-1:0] ^ pin_o[2*PORT_W-1:PORT_W]) & pin_oe[2*PORT_W-1:PORT_W]) == '0));
endmodule

bind exio_regs exio_regs_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_n    (ce_n),
   .oe_n    (oe_n),
   .we_n    (we_n),
   .rsel    (rsel),
   .data_o  (data_o),
   .data_oe (data_oe),
   .pin_o   (pin_o),
   .pin_oe  (pin_oe)
);

// File: tb/tb_exio_regs.sv
module tb_exio_regs;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b0;
   logic          oe_n = 1'b1;
   logic          we_n = 1'b1;
   logic [2:0]    rsel = 3'b000;
   logic [7:0]    data_i = 8'h00;
   logic [7:0]    data_o;
   logic          data_oe;
   logic [15:0]   pin_i = 16'h0000;
   logic [15:0]   pin_o;
   logic [15:0]   pin_oe;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exio_regs #(.PORT_W(PW), .DATA_W(8), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .rsel(rsel), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
      .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // strobe low for one cycle, then rising edge with the given data
   task automatic wr(input logic [2:0] code, input logic [7:0] v, input logic ce);
      @(negedge clk);
      ce_n = ce; rsel = code; data_i = v; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
   endtask

   task automatic rd(input logic [2:0] code, output logic [7:0] v, output logic oe);
      @(negedge clk);
      rsel = code; oe_n = 1'b0;
      #1;
      v = data_o; oe = data_oe;
      oe_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      logic       oe;
      logic [15:0] po, pe;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pin_oe", pin_oe, 16'h0000);
      chk("R1 pin_o", pin_o, 16'hFFFF);
      chk("R1 data_oe", data_oe, 1'b0);
      rd(3'b110, v, oe); chk("R1 dir0", v, 8'h00);
      rd(3'b111, v, oe); chk("R1 dir1", v, 8'h00);

      // R2 / R6 / R7 basic writes
      wr(3'b100, 8'h3C, 1'b0);
      chk("R2 port0", pin_o[7:0], 8'h3C);
      wr(3'b101, 8'hA1, 1'b0);
      chk("R2 port1", pin_o[15:8], 8'hA1);
      wr(3'b110, 8'h96, 1'b0);
      rd(3'b110, v, oe); chk("R6 dir0 read", v, 8'h96);
      chk("R7 pin_oe p0", pin_oe[7:0], 8'h96);
      wr(3'b111, 8'h0F, 1'b0);
      rd(3'b111, v, oe); chk("R6 dir1 read", v, 8'h0F);
      chk("R7 pin_oe p1", pin_oe[15:8], 8'h0F);
      chk("R7 p0 untouched by p1 dir", pin_oe[7:0], 8'h96);

      // R3 low select codes ignored
      po = pin_o; pe = pin_oe;
      for (int c = 0; c < 4; c++) begin
         wr(3'(c), 8'h55, 1'b0);
         chk("R3 pin_o", pin_o, po);
         chk("R3 pin_oe", pin_oe, pe);
      end
      rd(3'b110, v, oe); chk("R3 dir0 kept", v, 8'h96);

      // R4 chip enable high
      for (int c = 4; c < 8; c++) begin
         wr(3'(c), 8'hE7, 1'b1);
         chk("R4 pin_o", pin_o, po);
         chk("R4 pin_oe", pin_oe, pe);
      end
      @(negedge clk);
      ce_n = 1'b1; rsel = 3'b110; oe_n = 1'b0; #1;
      chk("R4 no drive", data_oe, 1'b0);
      oe_n = 1'b1; ce_n = 1'b0;
      rd(3'b111, v, oe); chk("R4 dir1 kept", v, 8'h0F);

      // R5 read gating
      rd(3'b010, v, oe); chk("R5 low sel no drive", oe, 1'b0);
      rd(3'b101, v, oe); chk("R5 drive", oe, 1'b1);
      @(negedge clk); rsel = 3'b100; oe_n = 1'b1; #1;
      chk("R5 oe_n high", data_oe, 1'b0);

      // R10 level strobe and data at edge
      @(negedge clk); rsel = 3'b110; data_i = 8'h11; we_n = 1'b0;
      @(negedge clk); data_i = 8'h22;
      @(negedge clk); data_i = 8'h33;
      chk("R10 held low", pin_oe[7:0], 8'h96);
      @(negedge clk); data_i = 8'h44; we_n = 1'b1;
      @(negedge clk); data_i = 8'h77;
      @(negedge clk); data_i = 8'h88;
      @(negedge clk);
      chk("R10 edge data", pin_oe[7:0], 8'h44);
      rd(3'b110, v, oe); chk("R10 held high", v, 8'h44);

      // R9 synchroniser latency
      wr(3'b110, 8'h00, 1'b0);
      pin_i[7:0] = 8'h00;
      repeat (3) @(negedge clk);
      pin_i[7:0] = 8'hC3; rsel = 3'b100; oe_n = 1'b0;
      @(negedge clk); #1;
      chk("R9 one edge old", data_o, 8'h00);
      @(negedge clk); #1;
      chk("R9 two edges new", data_o, 8'hC3);
      oe_n = 1'b1;

      // R8 sweep of all direction patterns on both ports
      for (int p = 0; p < 2; p++) begin
         for (int d = 0; d < 256; d++) begin
            logic [7:0] dv, pv, iv, ev;
            dv = 8'(d);
            pv = 8'((d * 37 + 11 + p * 5) % 256);
            iv = 8'((d * 91 + 5 + p * 13) % 256);
            ev = (pv & dv) | (iv & ~dv);
            wr(p == 0 ? 3'b110 : 3'b111, dv, 1'b0);
            wr(p == 0 ? 3'b100 : 3'b101, pv, 1'b0);
            @(negedge clk);
            if (p == 0) pin_i[7:0] = iv; else pin_i[15:8] = iv;
            @(negedge clk);
            @(negedge clk);
            rd(p == 0 ? 3'b100 : 3'b101, v, oe);
            chk("R8 mixed read", v, ev);
            if (p == 0) begin
               chk("R7 sweep oe p0", pin_oe[7:0], dv);
               chk("R7 sweep out p0", pin_o[7:0], pv);
            end else begin
               chk("R7 sweep oe p1", pin_oe[15:8], dv);
               chk("R7 sweep out p1", pin_o[15:8], pv);
            end
         end
      end

      finish_run();
   end
endmodule